// File: doc/BRIEF.md
# Test Access Port Instruction Register with Status Capture

This block holds the instruction of a boundary-scan test access port for a configurable device. A separate state machine supplies one-cycle strobes for the capture, shift, update and reset states. The block loads a capture word that reports live device status, shifts it out towards the serial output while a new opcode arrives from the serial input, and moves the new opcode into a holding register on the update strobe. A decoder turns the held opcode into one-hot select lines for the test data registers, and into two pin-control flags.

Four user instructions are honoured only while the configuration-complete input is high. Until then they select the bypass register. Any opcode outside the supported set also selects bypass and has no other effect. After reset the identification register is selected.

Top module: `tap_insn_reg`

## Requirements
- R1: While `trst_n` is low, and after it has been released, `dr_sel` is 8'b0000_0010 (identification register) and `pin_test_mode`, `pin_out_disable` and `tdo` are 0.
- R2: On a rising `tck` edge with `st_capture` high, the shift stage loads bit0=1, bit1=0, bit2=`stat_isc_done`, bit3=`stat_isc_en`, bit4=`stat_cleared`, bit5=`stat_released`.
- R3: On a rising edge with `st_shift` high, every shift-stage bit moves one place towards bit 0 and `tdi` enters bit 5. `tdo` shows bit 0 and changes only on the falling edge of `tck`, so the six bits of a capture word leave in order from bit 0 to bit 5.
- R4: The held opcode takes the shift-stage contents on a rising edge with `st_update` high and changes at no other time, apart from R5. The decode outputs therefore stay constant during capture and shift.
- R5: A rising edge with `st_reset` high loads the held opcode with 001001 (identification), even when `st_update` is high in the same cycle.
- R6: `dr_sel` bit positions are: 0 bypass, 1 identification, 2 user code, 3 boundary, 4..7 user registers 1..4. Opcode 001111, 000001 and 000111 select bit 3. Opcode 001000 selects bit 2, 001001 selects bit 1, and 111111 selects bit 0.
- R7: Opcodes 000010, 000011, 011010 and 011011 select `dr_sel` bits 4, 5, 6 and 7 only while `cfg_complete` is high, and select bit 0 otherwise. The gate follows `cfg_complete` live, without a new update.
- R8: Every opcode not listed in R6, R7 or R9 selects bit 0 and leaves `pin_test_mode` and `pin_out_disable` low.
- R9: Opcode 001010 selects bit 0 and raises `pin_out_disable` and `pin_test_mode`. Opcodes 001111 and 000111 raise `pin_test_mode` only. 000001 raises neither.
- R10: Exactly one bit of `dr_sel` is high at every rising edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_capture | input | 1 | Capture strobe for the instruction path |
| st_shift | input | 1 | Shift strobe for the instruction path |
| st_update | input | 1 | Update strobe for the instruction path |
| st_reset | input | 1 | Test-logic-reset strobe |
| tdi | input | 1 | Serial data in |
| stat_released | input | 1 | Status: done pin released |
| stat_cleared | input | 1 | Status: housekeeping finished |
| stat_isc_en | input | 1 | Status: in-system configuration enabled |
| stat_isc_done | input | 1 | Status: in-system configuration finished |
| cfg_complete | input | 1 | Configuration complete; enables user instructions |
| tdo | output | 1 | Serial data out, falling-edge timed |
| dr_sel | output | 8 | One-hot data register select |
| pin_test_mode | output | 1 | Steer pins away from core logic |
| pin_out_disable | output | 1 | Force output drivers off |

## Verification
The assertions assume that the state machine raises at most one of the capture, shift and update strobes in any cycle, and that every input changes away from the rising edge. The reset strobe is the only one that may overlap another. The bench drives every input one nanosecond after a rising edge. It issues the capture, shift and update strobes in the sequence a real scan uses, and it overlaps only reset with update, in the one check for that case. Status and configuration inputs change only between scans.

// File: rtl/tap_ir_pkg.sv
`timescale 1ns/1ps
package tap_ir_pkg;
  localparam int IR_W   = 6;
  localparam int N_USER = 4;

  // select line positions
  localparam int SEL_BYP  = 0;
  localparam int SEL_IDC  = 1;
  localparam int SEL_USC  = 2;
  localparam int SEL_BSR  = 3;
  localparam int SEL_USR0 = 4;
  localparam int NSEL     = SEL_USR0 + N_USER;

  localparam logic [IR_W-1:0] OP_EXTEST   = 6'b001111;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 6'b000001;
  localparam logic [IR_W-1:0] OP_INTEST   = 6'b000111;
  localparam logic [IR_W-1:0] OP_USERCODE = 6'b001000;
  localparam logic [IR_W-1:0] OP_IDCODE   = 6'b001001;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 6'b001010;
  localparam logic [IR_W-1:0] OP_BYPASS   = 6'b111111;

  function automatic logic [IR_W-1:0] user_op(input int idx);
    case (idx)
      0:       user_op = 6'b000010;
      1:       user_op = 6'b000011;
      2:       user_op = 6'b011010;
      default: user_op = 6'b011011;
    endcase
  endfunction
endpackage

// File: rtl/ir_rst_sync.sv
`timescale 1ns/1ps
module ir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ir_shift_stage.sv
`timescale 1ns/1ps
module ir_shift_stage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         tdi,
  input  logic [W-3:0] status,
  output logic [W-1:0] sr_q
);
  localparam int STAT_W = W - 2;
  localparam logic [1:0] CAP_TAIL = 2'b01;

  logic [W-1:0] sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = cap_en | shift_en;
    sr_d  = sr_q;
    if (cap_en)        sr_d = {status, CAP_TAIL};
    else if (shift_en) sr_d = {tdi, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assert_capture_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (sr_q[1:0] == 2'b01) && (sr_q[W-1 -: STAT_W] == $past(status)));

  assert_shift_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (sr_q[W-2:0] == $past(sr_q[W-1:1])) && (sr_q[W-1] == $past(tdi)));

  assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cap_en) |=> $stable(sr_q));
endmodule

// File: rtl/ir_shadow.sv
`timescale 1ns/1ps
module ir_shadow #(
  parameter int              W      = 6,
  parameter logic [W-1:0]    RST_OP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         tlr,
  input  logic [W-1:0] din,
  output logic [W-1:0] op_q
);
  logic [W-1:0] op_d;
  logic         op_en;

  always_comb begin
    op_en = upd_en | tlr;
    op_d  = tlr ? RST_OP : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= RST_OP;
    else if (op_en) op_q <= op_d;
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !tlr) |=> $stable(op_q));

  assert_update_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !tlr) |=> (op_q == $past(din)));

  assert_tlr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (op_q == RST_OP));
endmodule

// File: rtl/ir_decode.sv
`timescale 1ns/1ps
module ir_decode
  import tap_ir_pkg::*;
(
  input  logic [IR_W-1:0] op,
  input  logic            cfg_ok,
  output logic [NSEL-1:0] sel,
  output logic            test_mode,
  output logic            out_dis
);
  logic [N_USER-1:0] user_hit;
  logic [N_USER-1:0] user_ok;

  for (genvar u = 0; u < N_USER; u++) begin : g_user
    assign user_hit[u] = (op == user_op(u));
  end

  always_comb begin
    sel       = '0;
    test_mode = 1'b0;
    out_dis   = 1'b0;
    user_ok   = user_hit & {N_USER{cfg_ok}};
    case (op)
      OP_EXTEST:   begin sel[SEL_BSR] = 1'b1; test_mode = 1'b1; end
      OP_SAMPLE:   sel[SEL_BSR] = 1'b1;
      OP_INTEST:   begin sel[SEL_BSR] = 1'b1; test_mode = 1'b1; end
      OP_USERCODE: sel[SEL_USC] = 1'b1;
      OP_IDCODE:   sel[SEL_IDC] = 1'b1;
      OP_HIGHZ:    begin sel[SEL_BYP] = 1'b1; test_mode = 1'b1; out_dis = 1'b1; end
      default: begin
        if (|user_ok) sel[NSEL-1:SEL_USR0] = user_ok;
        else          sel[SEL_BYP] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tap_insn_reg.sv
`timescale 1ns/1ps
module tap_insn_reg
  import tap_ir_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            st_capture,
  input  logic            st_shift,
  input  logic            st_update,
  input  logic            st_reset,
  input  logic            tdi,
  input  logic            stat_released,
  input  logic            stat_cleared,
  input  logic            stat_isc_en,
  input  logic            stat_isc_done,
  input  logic            cfg_complete,
  output logic            tdo,
  output logic [NSEL-1:0] dr_sel,
  output logic            pin_test_mode,
  output logic            pin_out_disable
);
  logic            rst_n;
  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] op_q;
  logic [IR_W-3:0] status;
  logic            tdo_d;

  assign status = {stat_released, stat_cleared, stat_isc_en, stat_isc_done};

  ir_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n)
  );

  ir_shift_stage #(.W(IR_W)) u_shift (
    .clk(tck), .rst_n(rst_n), .cap_en(st_capture), .shift_en(st_shift),
    .tdi(tdi), .status(status), .sr_q(sr_q)
  );

  ir_shadow #(.W(IR_W), .RST_OP(OP_IDCODE)) u_hold (
    .clk(tck), .rst_n(rst_n), .upd_en(st_update), .tlr(st_reset),
    .din(sr_q), .op_q(op_q)
  );

  ir_decode u_dec (
    .op(op_q), .cfg_ok(cfg_complete), .sel(dr_sel),
    .test_mode(pin_test_mode), .out_dis(pin_out_disable)
  );

  // serial output retimed to the falling edge
  always_comb tdo_d = sr_q[0];

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo <= 1'b0;
    else        tdo <= tdo_d;
  end

  assert_tdo_bit0_R3: assert property (@(posedge tck) disable iff (!rst_n)
    tdo == sr_q[0]);

  assert_sel_onehot_R10: assert property (@(posedge tck) disable iff (!rst_n)
    $countones(dr_sel) == 1);

  assert_user_gated_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (|dr_sel[NSEL-1:SEL_USR0]) |-> cfg_complete);

  assert_hiz_bypass_R9: assert property (@(posedge tck) disable iff (!rst_n)
    pin_out_disable |-> (dr_sel[SEL_BYP] && pin_test_mode));

  assert_sel_steady_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (st_shift && $stable(cfg_complete)) |=> $stable(dr_sel));
endmodule

// File: tb/tap_insn_reg_tb_top.sv
`timescale 1ns/1ps
module tap_insn_reg_tb_top;
  logic       tck = 1'b0;
  logic       trst_n, st_capture, st_shift, st_update, st_reset, tdi;
  logic       stat_released, stat_cleared, stat_isc_en, stat_isc_done, cfg_complete;
  logic       tdo, pin_test_mode, pin_out_disable;
  logic [7:0] dr_sel;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 tck = ~tck;

  tap_insn_reg dut_i (
    .tck(tck), .trst_n(trst_n), .st_capture(st_capture), .st_shift(st_shift),
    .st_update(st_update), .st_reset(st_reset), .tdi(tdi),
    .stat_released(stat_released), .stat_cleared(stat_cleared),
    .stat_isc_en(stat_isc_en), .stat_isc_done(stat_isc_done),
    .cfg_complete(cfg_complete), .tdo(tdo), .dr_sel(dr_sel),
    .pin_test_mode(pin_test_mode), .pin_out_disable(pin_out_disable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(input logic [5:0] op, input logic cfg);
    case (op)
      6'b001111, 6'b000001, 6'b000111: exp_sel = 8'h08;
      6'b001000: exp_sel = 8'h04;
      6'b001001: exp_sel = 8'h02;
      6'b000010: exp_sel = cfg ? 8'h10 : 8'h01;
      6'b000011: exp_sel = cfg ? 8'h20 : 8'h01;
      6'b011010: exp_sel = cfg ? 8'h40 : 8'h01;
      6'b011011: exp_sel = cfg ? 8'h80 : 8'h01;
      default:   exp_sel = 8'h01;
    endcase
  endfunction

  function automatic logic exp_tm(input logic [5:0] op);
    exp_tm = (op == 6'b001111) || (op == 6'b000111) || (op == 6'b001010);
  endfunction

  // capture, six shifts, update; checks the capture word, steady selects, final decode
  task automatic ir_scan(input logic [5:0] op, input logic [3:0] stat,
                         input logic [7:0] sel_before);
    logic [5:0] got;
    logic [5:0] cap_exp;
    cap_exp = {stat, 2'b01};
    {stat_released, stat_cleared, stat_isc_en, stat_isc_done} = stat;
    @(posedge tck); #1 st_capture = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge tck); #1 st_capture = 1'b0; st_shift = 1'b1; tdi = op[k];
      #4 got[k] = tdo;
      chk("R4 select steady while shifting", dr_sel, sel_before);
    end
    chk("R2/R3 capture word out of tdo", got, cap_exp);
    @(posedge tck); #1 st_shift = 1'b0; st_update = 1'b1;
    @(posedge tck); #1 st_update = 1'b0;
    #1;
  endtask

  task automatic chk_decode(input logic [5:0] op);
    chk("R6/R7/R8 dr_sel", dr_sel, exp_sel(op, cfg_complete));
    chk("R9/R8 pin_test_mode", pin_test_mode, exp_tm(op));
    chk("R9/R8 pin_out_disable", pin_out_disable, op == 6'b001010);
    chk("R10 one-hot", $countones(dr_sel), 1);
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    trst_n = 1'b0; st_capture = 1'b0; st_shift = 1'b0; st_update = 1'b0;
    st_reset = 1'b0; tdi = 1'b0; cfg_complete = 1'b0;
    stat_released = 1'b0; stat_cleared = 1'b0; stat_isc_en = 1'b0; stat_isc_done = 1'b0;
    repeat (3) @(posedge tck);
    #2;
    chk("R1 sel in reset", dr_sel, 8'h02);
    chk("R1 tdo in reset", tdo, 1'b0);
    chk("R1 flags in reset", {pin_test_mode, pin_out_disable}, 2'b00);
    @(posedge tck); #1 trst_n = 1'b1;
    repeat (3) @(posedge tck);
    #2;
    chk("R1 sel after release", dr_sel, 8'h02);
    chk("R1 flags after release", {pin_test_mode, pin_out_disable}, 2'b00);

    // exhaustive opcode sweep for both gate states; status varies per scan
    prev = dr_sel;
    for (int c = 0; c < 2; c++) begin
      cfg_complete = c[0];
      #1 prev = dr_sel;
      for (int o = 0; o < 64; o++) begin
        ir_scan(o[5:0], o[3:0] ^ {c[0], 3'b101}, prev);
        chk_decode(o[5:0]);
        prev = dr_sel;
      end
    end

    // R7: gate follows cfg_complete live on a held user opcode
    cfg_complete = 1'b0;
    ir_scan(6'b011010, 4'hA, dr_sel);
    chk("R7 user3 gated off", dr_sel, 8'h01);
    @(posedge tck); #1 cfg_complete = 1'b1; #1;
    chk("R7 user3 live enable", dr_sel, 8'h40);
    @(posedge tck); #1 cfg_complete = 1'b0; #1;
    chk("R7 user3 live disable", dr_sel, 8'h01);

    // R5: reset strobe alone, then overlapping an update
    ir_scan(6'b001111, 4'h3, dr_sel);
    chk("R5 pre extest", dr_sel, 8'h08);
    @(posedge tck); #1 st_reset = 1'b1;
    @(posedge tck); #1 st_reset = 1'b0; #1;
    chk("R5 reset strobe loads id", dr_sel, 8'h02);
    chk("R5 flags cleared", {pin_test_mode, pin_out_disable}, 2'b00);
    ir_scan(6'b001010, 4'h5, dr_sel);
    chk("R9 highz", {dr_sel, pin_test_mode, pin_out_disable}, {8'h01, 2'b11});
    // shift in extest, then update together with reset
    {stat_released, stat_cleared, stat_isc_en, stat_isc_done} = 4'h0;
    @(posedge tck); #1 st_capture = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge tck); #1 st_capture = 1'b0; st_shift = 1'b1; tdi = 1'(6'b001111 >> k);
    end
    @(posedge tck); #1 st_shift = 1'b0; st_update = 1'b1; st_reset = 1'b1;
    @(posedge tck); #1 st_update = 1'b0; st_reset = 1'b0; #1;
    chk("R5 reset wins over update", dr_sel, 8'h02);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule